// File: doc/BRIEF.md
# Spread-Code Sequential Estimator with Verifier

This block acquires a maximal-length pseudo-noise sequence from a stream of soft chip samples. A sample arrives with a strobe, once per chip; nothing else in the block moves between strobes. The block slices the first `M` samples into hard chips and grades each one as trusted or doubtful by its magnitude. It accepts a window with no doubtful chip as it is. It repairs a window with exactly one doubtful chip using the shift-register recurrence. It discards a window with two or more doubtful chips.

An accepted estimate is loaded into a local `M`-stage Fibonacci shift register that uses the same feedback taps. The register then steps once per strobe. A verifier counts how often the locally predicted chip disagrees with the incoming hard decision over fixed windows of `VLEN` chips. Lock is declared after a window whose mismatch count stays within `VLIM`. Lock is withdrawn after any later window that exceeds it. Every rejection emits a one-cycle restart pulse and begins a fresh collection. Correlation, carrier recovery and chip timing are left to the surrounding receiver.

Top module: `pn_seq_acq`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `locked` low, `restart` low and `lfsr_state` all zeros, with the block collecting a new window.
- R2: A sample of zero or above is sliced to chip 0 and a negative sample to chip 1. During collection each strobe shifts the sliced chip into `lfsr_state[M-1]` and moves older chips toward bit 0. The chip received at sequence index n thus sits at bit `M-1-(k-n)` after index k.
- R3: A cycle without `chip_stb` changes neither `lfsr_state`, `locked` nor `restart` (restart falls or stays low), whatever `chip_sample` holds.
- R4: A chip is doubtful when its sample magnitude is below `THRESH`; a magnitude of exactly `THRESH` is trusted. If two or more of the `M` collected chips are doubtful, `restart` pulses on the strobe of the `M`-th chip and collection begins again.
- R5: With no doubtful chip and a nonzero window, the window becomes the register contents. Each later strobe shifts in the predicted chip `c[n] = XOR of c[n-M+i]` over every bit i set in `TAPS`, and `lfsr_state` follows the true sequence.
- R6: With exactly one doubtful chip, the first later trusted chip whose recurrence depends on the doubtful position fixes its value. `lfsr_state` then equals the true sequence state from that strobe on.
- R7: An all-zero estimate is never loaded; it causes a restart pulse instead. `locked` high implies a nonzero `lfsr_state`.
- R8: Verification counts mismatches between the predicted chip and the sliced sample over `VLEN` strobes, beginning with the strobe after loading. On the last strobe of the window, `locked` rises if the count is at most `VLIM`. Otherwise `restart` pulses.
- R9: While locked, the register keeps stepping and windows repeat. A window with more than `VLIM` mismatches drops `locked` and pulses `restart` on its last strobe. `restart` and `locked` are never high together.
- R10: `restart` is high for exactly one cycle per rejection.
- R11: If the doubtful chip is still unresolved after `2*M` strobes of repair, `restart` pulses on the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_stb | input | 1 | One pulse per received chip |
| chip_sample | input | SW | Signed soft chip sample, valid with `chip_stb` |
| lfsr_state | output | M | Local shift register; bit M-1 holds the newest chip |
| pn_chip | output | 1 | Newest locally held chip |
| locked | output | 1 | Sequence confirmed |
| restart | output | 1 | One-cycle pulse when an estimate or lock is rejected |

## Verification
The bench sweeps every nonzero starting phase of a 5-stage sequence. For each phase it places a wrong-signed doubtful chip at every window position, which catches a repair that writes the wrong bit or leaves the register one step out of phase. Samples of exactly the threshold and of the most negative code test the magnitude compare. A design off by one there would reject clean windows or accept doubtful ones. Mismatch counts of exactly `VLIM` and `VLIM+1` are placed both in the first window and in windows after lock, so an off-by-one window length or limit shows up as lock appearing a chip early or late. Repair timeout, all-zero windows and strobe-free cycles carrying junk samples round out the cases.

// File: rtl/pn_est_pkg.sv
package pn_est_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_CORRECT = 2'd1,
        ST_VERIFY  = 2'd2,
        ST_LOCKED  = 2'd3
    } acq_state_e;
endpackage

// File: rtl/pn_slicer.sv
module pn_slicer #(
    parameter int SW     = 8,
    parameter int THRESH = 16
) (
    input  logic signed [SW-1:0] sample,
    output logic                 chip,
    output logic                 trusted
);
    logic signed [SW:0] ext;
    logic [SW:0]        mag;

    always_comb begin
        ext     = {sample[SW-1], sample};
        mag     = sample[SW-1] ? $unsigned(-ext) : $unsigned(ext);
        chip    = sample[SW-1];
        trusted = (mag >= (SW+1)'(THRESH));
    end
endmodule

// File: rtl/pn_feedback.sv
module pn_feedback #(
    parameter int             M    = 5,
    parameter logic [M-1:0]   TAPS = 5'b00101
) (
    input  logic [M-1:0] state,
    output logic         fb
);
    assign fb = ^(state & TAPS);
endmodule

// File: rtl/pn_window.sv
module pn_window #(
    parameter int VLEN = 16,
    parameter int VLIM = 2,
    parameter int CW   = 5
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] miss,
    input  logic          miss_now,
    output logic [CW-1:0] pos_nx,
    output logic [CW-1:0] miss_nx,
    output logic          win_end,
    output logic          win_ok
);
    logic [CW-1:0] miss_sum;

    always_comb begin
        miss_sum = miss + CW'(miss_now);
        win_end  = (pos == CW'(VLEN - 1));
        win_ok   = (miss_sum <= CW'(VLIM));
        pos_nx   = win_end ? '0 : pos + CW'(1);
        miss_nx  = win_end ? '0 : miss_sum;
    end
endmodule

// File: rtl/pn_seq_acq.sv
module pn_seq_acq
    import pn_est_pkg::*;
#(
    parameter int           M      = 5,
    parameter logic [M-1:0] TAPS   = 5'b00101,
    parameter int           SW     = 8,
    parameter int           THRESH = 16,
    parameter int           VLEN   = 16,
    parameter int           VLIM   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chip_stb,
    input  logic signed [SW-1:0] chip_sample,
    output logic [M-1:0]         lfsr_state,
    output logic                 pn_chip,
    output logic                 locked,
    output logic                 restart
);
    localparam int CW    = $clog2(VLEN + 1);
    localparam int IW    = $clog2(M + 1);
    localparam int CSPAN = 2 * M;
    localparam int KW    = $clog2(CSPAN + 1);

    typedef struct packed {
        acq_state_e    st;
        logic [M-1:0]  sreg;
        logic [M-1:0]  flag;
        logic [M-1:0]  dvec;
        logic [IW-1:0] ncol;
        logic [1:0]    nunrel;
        logic [KW-1:0] ncorr;
        logic [CW-1:0] vpos;
        logic [CW-1:0] vmiss;
        logic          lock;
        logic          rs;
    } regs_t;

    regs_t q, d;

    logic          hd, rel, fb_s, fb_d, mis;
    logic [CW-1:0] vpos_nx, vmiss_nx;
    logic          win_end, win_ok;

    pn_slicer #(.SW(SW), .THRESH(THRESH)) slicer_i (
        .sample(chip_sample), .chip(hd), .trusted(rel)
    );

    pn_feedback #(.M(M), .TAPS(TAPS)) fb_state_i (.state(q.sreg), .fb(fb_s));
    pn_feedback #(.M(M), .TAPS(TAPS)) fb_dep_i   (.state(q.dvec), .fb(fb_d));

    assign mis = fb_s ^ hd;

    pn_window #(.VLEN(VLEN), .VLIM(VLIM), .CW(CW)) window_i (
        .pos(q.vpos), .miss(q.vmiss), .miss_now(mis),
        .pos_nx(vpos_nx), .miss_nx(vmiss_nx),
        .win_end(win_end), .win_ok(win_ok)
    );

    function automatic regs_t fresh_start();
        regs_t r;
        r    = '0;
        r.st = ST_COLLECT;
        r.rs = 1'b1;
        return r;
    endfunction

    logic [M-1:0] col_s, col_f, a_n, d_n, fixed;
    logic [1:0]   nun;

    always_comb begin
        d     = q;
        d.rs  = 1'b0;
        col_s = {hd, q.sreg[M-1:1]};
        col_f = {~rel, q.flag[M-1:1]};
        nun   = (q.nunrel == 2'd2) ? 2'd2 : q.nunrel + {1'b0, ~rel};
        a_n   = {fb_s, q.sreg[M-1:1]};
        d_n   = {fb_d, q.dvec[M-1:1]};
        fixed = a_n ^ ({M{hd ^ fb_s}} & d_n);

        if (chip_stb) begin
            unique case (q.st)
                ST_COLLECT: begin
                    if (q.ncol == IW'(M - 1)) begin
                        if (nun == 2'd2) begin
                            d = fresh_start();
                        end else if (nun == 2'd1) begin
                            d.st     = ST_CORRECT;
                            d.sreg   = col_s & ~col_f;
                            d.dvec   = col_f;
                            d.flag   = '0;
                            d.ncol   = '0;
                            d.nunrel = '0;
                            d.ncorr  = '0;
                        end else if (col_s == '0) begin
                            d = fresh_start();
                        end else begin
                            d.st     = ST_VERIFY;
                            d.sreg   = col_s;
                            d.flag   = '0;
                            d.ncol   = '0;
                            d.nunrel = '0;
                            d.vpos   = '0;
                            d.vmiss  = '0;
                        end
                    end else begin
                        d.sreg   = col_s;
                        d.flag   = col_f;
                        d.nunrel = nun;
                        d.ncol   = q.ncol + IW'(1);
                    end
                end
                ST_CORRECT: begin
                    if (fb_d && rel) begin
                        if (fixed == '0) begin
                            d = fresh_start();
                        end else begin
                            d.st    = ST_VERIFY;
                            d.sreg  = fixed;
                            d.dvec  = '0;
                            d.ncorr = '0;
                            d.vpos  = '0;
                            d.vmiss = '0;
                        end
                    end else if (q.ncorr == KW'(CSPAN - 1)) begin
                        d = fresh_start();
                    end else begin
                        d.sreg  = a_n;
                        d.dvec  = d_n;
                        d.ncorr = q.ncorr + KW'(1);
                    end
                end
                default: begin
                    d.sreg  = a_n;
                    d.vpos  = vpos_nx;
                    d.vmiss = vmiss_nx;
                    if (win_end) begin
                        if (win_ok) begin
                            d.st   = ST_LOCKED;
                            d.lock = 1'b1;
                        end else begin
                            d = fresh_start();
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign lfsr_state = q.sreg;
    assign pn_chip    = q.sreg[M-1];
    assign locked     = q.lock;
    assign restart    = q.rs;
endmodule

// File: rtl/pn_seq_acq_chk.sv
module pn_seq_acq_chk #(
    parameter int M = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         chip_stb,
    input logic [M-1:0] lfsr_state,
    input logic         locked,
    input logic         restart
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!locked && !restart && lfsr_state == '0));

    assert_idle_state_R3: assert property (@(posedge clk) disable iff (rst)
        !chip_stb |=> ($stable(lfsr_state) && $stable(locked) && !restart));

    assert_lock_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        locked |-> (lfsr_state != '0));

    assert_lock_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(chip_stb));

    assert_no_lock_on_restart_R9: assert property (@(posedge clk) disable iff (rst)
        restart |-> !locked);

    assert_restart_single_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);
endmodule

bind pn_seq_acq pn_seq_acq_chk #(.M(M)) chk_i (
    .clk(clk), .rst(rst), .chip_stb(chip_stb),
    .lfsr_state(lfsr_state), .locked(locked), .restart(restart)
);

// File: tb/pn_seq_acq_tb.sv
module pn_seq_acq_tb_top;
    localparam int           M      = 5;
    localparam logic [M-1:0] TAPS   = 5'b00101;
    localparam int           SW     = 8;
    localparam int           THRESH = 16;
    localparam int           VLEN   = 16;
    localparam int           VLIM   = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 chip_stb = 1'b0;
    logic signed [SW-1:0] chip_sample = '0;
    logic [M-1:0]         lfsr_state;
    logic                 pn_chip, locked, restart;

    int n_chk  = 0;
    int n_fail = 0;
    int junk   = 37;
    logic chips [0:127];

    always #2 clk = ~clk;

    pn_seq_acq #(.M(M), .TAPS(TAPS), .SW(SW), .THRESH(THRESH),
                 .VLEN(VLEN), .VLIM(VLIM)) dut_i (
        .clk(clk), .rst(rst), .chip_stb(chip_stb), .chip_sample(chip_sample),
        .lfsr_state(lfsr_state), .pn_chip(pn_chip), .locked(locked), .restart(restart)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic build(input int seed);
        for (int i = 0; i < M; i++) chips[i] = seed[i];
        for (int n = M; n < 128; n++) begin
            logic p;
            p = 1'b0;
            for (int i = 0; i < M; i++) if (TAPS[i]) p ^= chips[n-M+i];
            chips[n] = p;
        end
    endtask

    function automatic int true_state(input int n);
        logic [M-1:0] s;
        for (int j = 0; j < M; j++) s[M-1-j] = chips[n-j];
        return int'(s);
    endfunction

    task automatic send(input logic chip, input int amp);
        @(negedge clk);
        chip_stb    = 1'b1;
        chip_sample = chip ? SW'(-amp) : SW'(amp);
        @(posedge clk);
        #1;
        chip_stb    = 1'b0;
        junk        = (junk * 73 + 11) % 256;
        chip_sample = SW'(junk - 128);
    endtask

    task automatic gap();
        @(negedge clk);
        chip_stb = 1'b0;
        chip_sample = SW'(junk);
        @(posedge clk);
        #1;
    endtask

    function automatic int amp_of(input int n);
        return THRESH + (n * 7) % (128 - THRESH);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        check(!locked && !restart && lfsr_state == '0, "R1 reset", int'(lfsr_state), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [M-1:0] hold;
        bit seen_rs;

        // R2 slicing and shift order, R3 strobe-free cycle
        do_reset();
        send(1'b0, 127);
        check(lfsr_state[M-1] == 1'b0, "R2 positive slice", int'(lfsr_state[M-1]), 0);
        send(1'b1, 128);
        check(lfsr_state[M-1:M-2] == 2'b10, "R2 most negative slice", int'(lfsr_state[M-1:M-2]), 2);
        hold = lfsr_state;
        gap();
        gap();
        check(lfsr_state == hold && !restart && !locked, "R3 idle hold", int'(lfsr_state), int'(hold));
        send(1'b0, THRESH);
        check(lfsr_state[M-1:M-3] == 3'b010, "R2 threshold slice", int'(lfsr_state[M-1:M-3]), 2);

        // R5 every nonzero phase, clean samples
        for (int seed = 1; seed < 32; seed++) begin
            do_reset();
            build(seed);
            for (int n = 0; n <= 20; n++) begin
                send(chips[n], amp_of(n));
                if (n % 6 == 3) gap();
                if (n == M-1)
                    check(int'(lfsr_state) == true_state(n), "R5 seed load", int'(lfsr_state), true_state(n));
                if (n == 19)
                    check(!locked, "R8 lock not early", int'(locked), 0);
            end
            check(locked && int'(lfsr_state) == true_state(20), "R5 tracking and R8 lock",
                  int'(lfsr_state), true_state(20));
        end

        // R6 one doubtful wrong-signed chip at every position
        for (int seed = 1; seed < 32; seed++) begin
            for (int k = 0; k < M; k++) begin
                do_reset();
                build(seed);
                seen_rs = 1'b0;
                for (int n = 0; n <= 25; n++) begin
                    if (n == k) send(~chips[n], THRESH - 1);
                    else        send(chips[n], amp_of(n));
                    if (restart) seen_rs = 1'b1;
                end
                check(locked && !seen_rs && int'(lfsr_state) == true_state(25),
                      "R6 single repair", int'(lfsr_state), true_state(25));
            end
        end

        // R4 two doubtful chips, then a clean retry
        do_reset();
        build(9);
        for (int n = 0; n < M; n++) begin
            if (n == 1 || n == 3) send(chips[n], THRESH - 1);
            else                  send(chips[n], amp_of(n));
            if (n == M-2) check(!restart, "R4 no early restart", int'(restart), 0);
        end
        check(restart && !locked, "R4 two doubtful restart", int'(restart), 1);
        gap();
        check(!restart, "R10 single pulse", int'(restart), 0);
        for (int n = 0; n <= 20; n++) send(chips[n], amp_of(n));
        check(locked && int'(lfsr_state) == true_state(20), "R4 retry locks",
              int'(lfsr_state), true_state(20));

        // R7 all-zero window
        do_reset();
        for (int n = 0; n < M; n++) send(1'b0, 100);
        check(restart && !locked, "R7 zero window rejected", int'(restart), 1);
        send(1'b0, 100);
        check(!restart, "R10 single pulse after zero", int'(restart), 0);

        // R8 limit exceeded in the first window
        do_reset();
        build(5);
        for (int n = 0; n <= 20; n++) begin
            if (n == 6 || n == 9 || n == 12) send(~chips[n], amp_of(n));
            else                             send(chips[n], amp_of(n));
        end
        check(restart && !locked, "R8 over limit rejected", int'(restart), 1);
        gap();
        check(!restart, "R10 pulse width", int'(restart), 0);

        // R8 exactly at the limit
        do_reset();
        build(5);
        for (int n = 0; n <= 20; n++) begin
            if (n == 6 || n == 9) send(~chips[n], amp_of(n));
            else                  send(chips[n], amp_of(n));
        end
        check(locked && !restart, "R8 at limit locks", int'(locked), 1);

        // R9 lock held at limit, dropped above it
        do_reset();
        build(7);
        for (int n = 0; n <= 52; n++) begin
            if (n == 22 || n == 30 || n == 40 || n == 44 || n == 50) send(~chips[n], amp_of(n));
            else send(chips[n], amp_of(n));
            if (n == 20) check(locked, "R9 first lock", int'(locked), 1);
            if (n == 36) check(locked && !restart && int'(lfsr_state) == true_state(36),
                               "R9 lock kept at limit", int'(lfsr_state), true_state(36));
            if (n == 51) check(locked, "R9 lock until window end", int'(locked), 1);
        end
        check(!locked && restart, "R9 lock dropped", int'(locked), 0);

        // R11 repair timeout
        do_reset();
        build(3);
        for (int n = 0; n <= 4 + 2*M; n++) begin
            if (n == 2 || n >= M) send(chips[n], THRESH / 2);
            else                  send(chips[n], amp_of(n));
            if (n == 3 + 2*M) check(!restart, "R11 no early timeout", int'(restart), 0);
        end
        check(restart && !locked, "R11 timeout restart", int'(restart), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule